// File: doc/BRIEF.md
# Register-Renaming Out-of-Order ALU Core

This block executes a stream of decoded two-source ALU instructions out of order while retiring them in program order. A rename table maps every architectural register either to a committed value or to the slot of a circular reorder buffer that will produce it. Instructions enter at the buffer tail and pick up their operands from that table. An operand that is still pending waits on the slot's tag and captures the value when the ALU broadcasts a result with that tag on the shared result bus.

A single ALU with one cycle of latency takes the ready entry nearest the head. Finished entries leave from the head one per cycle, update the architectural register file and appear on the retire port. A flush input discards all work in flight and restores the rename table from the committed register values. Registers reset to zero, so software seeds them with the add-immediate operation.

Top module: `ooo_rename_core`

## Requirements
- R1: After reset the buffer is empty, `in_ready` is 1, `ret_valid` is 0 and every architectural register holds 0.
- R2: The opcode on `in_op` selects the result: 0 gives src1+src2, 1 gives src1-src2, 2 gives src1 XOR src2, 3 gives src1+`in_imm`. All arithmetic wraps at DW bits.
- R3: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly when DEPTH instructions are in flight or `flush` is 1.
- R4: Instructions retire strictly in acceptance order, at most one per cycle. `ret_dst` and `ret_data` give the destination and result of the retiring instruction while `ret_valid` is 1.
- R5: Every source operand sees the result of the youngest earlier accepted instruction that writes that register, or the committed value when there is no such instruction. This holds whether that producer is waiting, executing, finished or retiring in the same cycle.
- R6: An instruction whose operands are available issues in the cycle after acceptance, and its result appears on the retire port two cycles later. A dependent instruction is woken by the result broadcast and issues in the following cycle. Among ready entries, the oldest issues first.
- R7: While `flush` is 1, no instruction is accepted or retired. After the flush edge, the buffer is empty and every register reads its last retired value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | The core can accept an instruction this cycle |
| in_op | input | 2 | Operation code (see R2) |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| in_imm | input | DW | Immediate for the add-immediate operation |
| flush | input | 1 | Discard all in-flight instructions |
| ret_valid | output | 1 | An instruction retires this cycle |
| ret_dst | output | $clog2(NREG) | Destination register of the retiring instruction |
| ret_data | output | DW | Value written to that register |

## Verification
The bench targets back-to-back dependencies. If wakeup on the result bus were missed, the dependent instruction would never issue. If a finished producer were not checked at dispatch, the consumer would wait for a broadcast that has already passed. Both faults show up as a stall or a wrong retired value. Dependent chains keep the buffer full, so a wrong full test would either lose an instruction or overwrite a live slot. Flushes are applied while results are still in the ALU and are followed by reads of every register. These reads expose a stale rename entry or a late broadcast written into a reused slot. A fixed-latency pattern pins down the one-cycle issue and wakeup timing.

// File: rtl/ooo_rename_core.sv
module ooo_rename_core #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_op,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  input  logic [DW-1:0]           in_imm,
  input  logic                    flush,
  output logic                    ret_valid,
  output logic [$clog2(NREG)-1:0] ret_dst,
  output logic [DW-1:0]           ret_data
);
  localparam int RW = $clog2(NREG);
  localparam int TW = $clog2(DEPTH);
  localparam int PW = TW + 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  typedef struct packed {
    logic          rdy;
    logic [TW-1:0] tag;
    logic [DW-1:0] val;
  } opnd_t;

  logic [PW-1:0] head, tail, cnt;
  logic [TW-1:0] hidx, tidx;
  assign hidx = head[TW-1:0];
  assign tidx = tail[TW-1:0];
  assign cnt  = tail - head;

  logic [DW-1:0] arf    [NREG];
  logic          rn_vld [NREG];
  logic [TW-1:0] rn_tag [NREG];
  logic [DW-1:0] rn_val [NREG];

  logic          e_vld  [DEPTH];
  logic          e_done [DEPTH];
  logic          e_iss  [DEPTH];
  logic [1:0]    e_op   [DEPTH];
  logic [RW-1:0] e_dst  [DEPTH];
  logic [DW-1:0] e_imm  [DEPTH];
  logic [DW-1:0] e_res  [DEPTH];
  logic          e_r1   [DEPTH];
  logic [TW-1:0] e_t1   [DEPTH];
  logic [DW-1:0] e_v1   [DEPTH];
  logic          e_r2   [DEPTH];
  logic [TW-1:0] e_t2   [DEPTH];
  logic [DW-1:0] e_v2   [DEPTH];

  logic          alu_vld;
  logic [TW-1:0] alu_tag;
  logic [DW-1:0] alu_res;

  assign in_ready  = (cnt != FULL) && !flush;
  assign ret_valid = e_vld[hidx] && e_done[hidx] && !flush;
  assign ret_dst   = e_dst[hidx];
  assign ret_data  = e_res[hidx];

  logic do_disp;
  assign do_disp = in_valid && in_ready;

  function automatic opnd_t look(input logic [RW-1:0] r);
    opnd_t o;
    o.tag = rn_tag[r];
    o.rdy = 1'b1;
    if (rn_vld[r])                          o.val = rn_val[r];
    else if (e_done[rn_tag[r]])             o.val = e_res[rn_tag[r]];
    else if (alu_vld && alu_tag == rn_tag[r]) o.val = alu_res;
    else begin
      o.rdy = 1'b0;
      o.val = '0;
    end
    return o;
  endfunction

  opnd_t op1, op2;
  assign op1 = look(in_src1);
  assign op2 = look(in_src2);

  logic          iss_go;
  logic [TW-1:0] iss_idx;
  always_comb begin
    iss_go  = 1'b0;
    iss_idx = hidx;
    for (int k = 0; k < DEPTH; k++) begin
      if (!iss_go && e_vld[hidx + TW'(k)] && !e_done[hidx + TW'(k)] && !e_iss[hidx + TW'(k)]
          && e_r1[hidx + TW'(k)] && e_r2[hidx + TW'(k)]) begin
        iss_go  = 1'b1;
        iss_idx = hidx + TW'(k);
      end
    end
  end

  logic [DW-1:0] alu_out;
  always_comb begin
    case (e_op[iss_idx])
      2'd0:    alu_out = e_v1[iss_idx] + e_v2[iss_idx];
      2'd1:    alu_out = e_v1[iss_idx] - e_v2[iss_idx];
      2'd2:    alu_out = e_v1[iss_idx] ^ e_v2[iss_idx];
      default: alu_out = e_v1[iss_idx] + e_imm[iss_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      alu_vld <= 1'b0;
      alu_tag <= '0;
      alu_res <= '0;
      for (int r = 0; r < NREG; r++) begin
        arf[r]    <= '0;
        rn_vld[r] <= 1'b1;
        rn_tag[r] <= '0;
        rn_val[r] <= '0;
      end
      for (int e = 0; e < DEPTH; e++) begin
        e_vld[e]  <= 1'b0;
        e_done[e] <= 1'b0;
        e_iss[e]  <= 1'b0;
        e_op[e]   <= '0;
        e_dst[e]  <= '0;
        e_imm[e]  <= '0;
        e_res[e]  <= '0;
        e_r1[e]   <= 1'b0;
        e_t1[e]   <= '0;
        e_v1[e]   <= '0;
        e_r2[e]   <= 1'b0;
        e_t2[e]   <= '0;
        e_v2[e]   <= '0;
      end
    end else if (flush) begin
      tail    <= head;
      alu_vld <= 1'b0;
      for (int e = 0; e < DEPTH; e++) e_vld[e] <= 1'b0;
      for (int r = 0; r < NREG; r++) begin
        rn_vld[r] <= 1'b1;
        rn_val[r] <= arf[r];
      end
    end else begin
      alu_vld <= iss_go;
      alu_tag <= iss_idx;
      alu_res <= alu_out;
      if (iss_go) e_iss[iss_idx] <= 1'b1;

      if (alu_vld) begin
        e_done[alu_tag] <= 1'b1;
        e_res[alu_tag]  <= alu_res;
        for (int e = 0; e < DEPTH; e++) begin
          if (e_vld[e] && !e_r1[e] && e_t1[e] == alu_tag) begin
            e_r1[e] <= 1'b1;
            e_v1[e] <= alu_res;
          end
          if (e_vld[e] && !e_r2[e] && e_t2[e] == alu_tag) begin
            e_r2[e] <= 1'b1;
            e_v2[e] <= alu_res;
          end
        end
      end

      if (ret_valid) begin
        arf[e_dst[hidx]] <= e_res[hidx];
        e_vld[hidx]      <= 1'b0;
        head             <= head + 1'b1;
        if (!rn_vld[e_dst[hidx]] && rn_tag[e_dst[hidx]] == hidx) begin
          rn_vld[e_dst[hidx]] <= 1'b1;
          rn_val[e_dst[hidx]] <= e_res[hidx];
        end
      end

      if (do_disp) begin
        e_vld[tidx]  <= 1'b1;
        e_done[tidx] <= 1'b0;
        e_iss[tidx]  <= 1'b0;
        e_op[tidx]   <= in_op;
        e_dst[tidx]  <= in_dst;
        e_imm[tidx]  <= in_imm;
        e_r1[tidx]   <= op1.rdy;
        e_t1[tidx]   <= op1.tag;
        e_v1[tidx]   <= op1.val;
        e_r2[tidx]   <= op2.rdy;
        e_t2[tidx]   <= op2.tag;
        e_v2[tidx]   <= op2.val;
        rn_vld[in_dst] <= 1'b0;
        rn_tag[in_dst] <= tidx;
        tail           <= tail + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (cnt == '0 && !alu_vld && !ret_valid)); // R7
  AST_BCAST_LIVE: assert property (@(posedge clk) disable iff (!rst_n) alu_vld |-> (e_vld[alu_tag] && e_iss[alu_tag] && !e_done[alu_tag])); // R6
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n) ret_valid |=> head == PW'($past(head) + 1'b1)); // R4

  for (genvar g = 0; g < NREG; g++) begin : g_rn_chk
    logic [TW-1:0] off;
    assign off = rn_tag[g] - hidx;
    AST_RENAME_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !rn_vld[g] |-> ({1'b0, off} < cnt && e_dst[rn_tag[g]] == RW'(g))); // R5
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent_chk
    logic [TW-1:0] eoff, roff;
    assign eoff = TW'(g) - hidx;
    assign roff = rn_tag[e_dst[g]] - hidx;
    AST_ENTRY_RENAMED: assert property (@(posedge clk) disable iff (!rst_n)
      e_vld[g] |-> (!rn_vld[e_dst[g]] && roff >= eoff && {1'b0, roff} < cnt)); // R5
  end
endmodule

// File: tb/sim_ooo_rename_core.sv
module sim_ooo_rename_core;
  localparam int DW = 16, NREG = 8, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, flush = 1'b0;
  logic [1:0] in_op = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [DW-1:0] in_imm = '0;
  logic in_ready, ret_valid;
  logic [2:0] ret_dst;
  logic [DW-1:0] ret_data;

  always #2 clk = ~clk;

  ooo_rename_core #(.DW(DW), .NREG(NREG), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_imm(in_imm), .flush(flush), .ret_valid(ret_valid),
    .ret_dst(ret_dst), .ret_data(ret_data));

  int total = 0, fails = 0, idle_run = 0;
  logic [DW-1:0] spec [NREG];
  logic [DW-1:0] arch [NREG];
  logic [2:0]    q_dst [$];
  logic [DW-1:0] q_val [$];
  bit last_ret, saw_stall;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_alu(input logic [1:0] op, input logic [DW-1:0] a,
                                            input logic [DW-1:0] b, input logic [DW-1:0] imm);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a + imm;
    endcase
  endfunction

  task automatic cyc(input bit v, input logic [1:0] op, input logic [2:0] d,
                     input logic [2:0] s1, input logic [2:0] s2,
                     input logic [DW-1:0] imm, input bit fl);
    bit exp_rdy;
    @(negedge clk);
    in_valid = v; in_op = op; in_dst = d; in_src1 = s1; in_src2 = s2; in_imm = imm; flush = fl;
    #1;
    exp_rdy = (q_dst.size() < DEPTH) && !fl;
    chk(in_ready == exp_rdy, "R3", "in_ready", in_ready, exp_rdy);
    if (!in_ready && !fl) saw_stall = 1;
    last_ret = ret_valid;
    if (fl) chk(!ret_valid, "R7", "retire during flush", ret_valid, 0);
    if (ret_valid) begin
      if (q_dst.size() == 0) chk(0, "R4", "retire with nothing in flight", 1, 0);
      else begin
        chk(ret_dst == q_dst[0], "R4", "ret_dst order", ret_dst, q_dst[0]);
        chk(ret_data == q_val[0], "R2 R5", "ret_data", ret_data, q_val[0]);
        if (!fl) begin
          arch[q_dst[0]] = q_val[0];
          void'(q_dst.pop_front());
          void'(q_val.pop_front());
        end
      end
    end
    if (q_dst.size() != 0 && !ret_valid) idle_run++; else idle_run = 0;
    if (idle_run == 20) chk(0, "R6", "no retire progress", 0, 1);
    if (fl) begin
      q_dst.delete(); q_val.delete();
      for (int r = 0; r < NREG; r++) spec[r] = arch[r];
    end else if (v && in_ready) begin
      logic [DW-1:0] res;
      res = ref_alu(op, spec[s1], spec[s2], imm);
      q_dst.push_back(d);
      q_val.push_back(res);
      spec[d] = res;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic read_all();
    for (int r = 0; r < NREG; r++) begin
      cyc(1, 2'd3, 3'(r), 3'(r), 0, 0, 0);
      while (!in_ready) cyc(1, 2'd3, 3'(r), 3'(r), 0, 0, 0);
    end
    idle(12);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin spec[r] = '0; arch[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(ret_valid == 1'b0, "R1", "ret_valid after reset", ret_valid, 0);
    read_all();  // R1: all registers read back as zero

    // R6 timing: independent producer then dependent consumer
    cyc(1, 2'd3, 3'd1, 3'd0, 0, 16'd5, 0);
    cyc(1, 2'd0, 3'd2, 3'd1, 3'd1, 0, 0);
    chk(!last_ret, "R6", "no retire one cycle after dispatch", last_ret, 0);
    idle(1);
    chk(!last_ret, "R6", "no retire two cycles after dispatch", last_ret, 0);
    idle(1);
    chk(last_ret, "R6", "producer retires after issue+alu", last_ret, 1);
    idle(1);
    chk(!last_ret, "R6", "consumer not yet done", last_ret, 0);
    idle(1);
    chk(last_ret, "R6", "consumer woken by broadcast", last_ret, 1);
    idle(4);

    // R2 each opcode, including wrap
    cyc(1, 2'd3, 3'd3, 3'd0, 0, 16'hFFFF, 0);
    cyc(1, 2'd0, 3'd4, 3'd3, 3'd2, 0, 0);
    cyc(1, 2'd1, 3'd5, 3'd1, 3'd2, 0, 0);
    cyc(1, 2'd2, 3'd6, 3'd3, 3'd1, 0, 0);
    idle(12);

    // R3 fill the buffer with a dependent chain
    saw_stall = 0;
    for (int i = 0; i < 12; i++) cyc(1, 2'd0, 3'd7, 3'd7, 3'd1, 0, 0);
    chk(saw_stall, "R3", "full buffer stalls dispatch", saw_stall, 1);
    idle(20);

    // R7 flush with work in flight, then read every register
    cyc(1, 2'd3, 3'd1, 3'd1, 0, 16'd100, 0);
    cyc(1, 2'd0, 3'd2, 3'd1, 3'd1, 0, 0);
    cyc(1, 2'd3, 3'd3, 3'd2, 0, 16'd7, 0);
    cyc(1, 2'd2, 3'd1, 3'd3, 3'd2, 0, 1);
    read_all();
    cyc(1, 2'd3, 3'd4, 3'd4, 0, 16'd9, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    read_all();

    // R5 random streams with occasional flushes
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rn;
      rn = $urandom;
      cyc(rn[3:0] != 0, rn[5:4], rn[8:6], rn[11:9], rn[14:12], rn[31:16], rn[22:17] == 0);
    end
    idle(20);
    chk(q_dst.size() == 0, "R4", "all work retired", q_dst.size(), 0);
    read_all();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule